// File: doc/BRIEF.md
# Symmetric PWM Channel with Dead-Band and Pin Overrides

This block is one center-aligned PWM channel for motor-drive use. A timebase counter runs up from zero to a programmable period and back down again. A compare value decides where output A drops on the rising leg, and the period event raises it again. Both the period and the compare value are written into holding registers. They reach the live logic only when the counter passes through zero. This keeps a mid-cycle update from tearing the current pulse. It also keeps the first pulse after a change from a zero compare correct.

A dead-band stage turns A into a complementary pair with separate delays for the rising edges of each pin, or it passes A and its inverse through unchanged. After that stage, a per-pin override code can pin either output high or low, or release it. Software can also load the counter directly. A sync input can load a phase value so that several channels run in lock-step. A channel set as master drives its sync output while its counter sits at zero. Otherwise the sync output repeats the sync input, so that channels can be daisy-chained.

All configuration goes through a single-cycle write port. Each address selects a register: 0 period, 1 compare, 2 counter, 3 phase, 4 override codes, 5 control, 6 delay before a pin rises on A's side, 7 delay before the complementary pin rises.

Top module: `cpwm_channel`

## Requirements
- R1: The count steps by one per clock: up from 0 to the active period P, then down to 0, giving a repeat of 2P cycles. While the active period is 0, the count holds at 0.
- R2: Writes to address 0 (period) and address 1 (compare) land in holding registers. Each is copied to its live register only on a cycle where the count is 0, so a period written mid-cycle leaves the running peak unchanged.
- R3: Output A is set on the clock after the count equals the active period. In bypass with no override, A is high for min(P+C, 2P) cycles out of every 2P.
- R4: Output A is cleared on the clock after the count equals the compare value C while the next step is upward, provided C < P.
- R5: A compare value equal to or above the period keeps A high for the entire cycle.
- R6: Control bit 0 set selects full dead-band mode. In this mode pwm_a rises a number of cycles given by address 6 after A rises, and pwm_b (high while A is low) rises a number of cycles given by address 7 after A falls. pwm_a and pwm_b are never both high.
- R7: Control bit 0 clear selects bypass: pwm_a equals A and pwm_b equals the inverse of A, with no delay.
- R8: Address 4 holds the override code for pwm_a in bits [1:0] and for pwm_b in bits [3:2]. Code 1 drives the pin low and code 2 drives it high. Codes 0 and 3 release the pin. The override acts after the dead-band stage.
- R9: With control bit 2 set, sync_out is high exactly while the count is 0. With bit 2 clear, sync_out follows sync_in.
- R10: A write to address 2 puts the written value on the count at the next clock, and counting resumes from it.
- R11: With control bit 1 set, a high sync_in loads the phase value (address 3) into the count at the next clock, and counting proceeds upward. A counter write takes priority.
- R12: A compare of zero clears A at the count-zero point. When the compare changes from zero to C, the first following period already shows the full P+C high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| sync_in | input | 1 | Sync from the previous channel |
| sync_out | output | 1 | Sync to the next channel |
| count | output | CNT_W | Timebase count |
| pwm_a | output | 1 | Main PWM pin |
| pwm_b | output | 1 | Complementary PWM pin |

## Verification
The duty cycle is measured over full periods for compare values below the period, equal to it, above it, and zero. These show whether set and clear happen on the right events and whether the compare ceiling saturates. A zero-to-non-zero compare change and a mid-cycle period write are each followed across the next zero crossing, which separates correct zero-point loading from loading too early or too late. Dead-band delays, the four override codes, counter presets and sync-driven phase loads are each applied while a cycle-by-cycle model tracks count, both pins and the sync output, so any error in edge placement or ordering is seen in the exact cycle it occurs.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADDR_W = 3;
  localparam int FRC_W  = 2;

  localparam logic [ADDR_W-1:0] A_PRD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PHS   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FRC   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_DLY_A = 3'd6;
  localparam logic [ADDR_W-1:0] A_DLY_B = 3'd7;

  typedef enum logic [FRC_W-1:0] {
    OVR_OFF  = 2'd0,
    OVR_LOW  = 2'd1,
    OVR_HIGH = 2'd2,
    OVR_OFF3 = 2'd3
  } ovr_e;

  // Override applied to one pin after dead-band.
  function automatic logic apply_ovr(input logic [FRC_W-1:0] code, input logic lvl);
    case (code)
      OVR_LOW:  return 1'b0;
      OVR_HIGH: return 1'b1;
      default:  return lvl;
    endcase
  endfunction
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_wr,
  input  logic             cnt_wr,
  input  logic             sync_load,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] phase_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd_act,
  output logic             at_zero,
  output logic             at_prd,
  output logic             rising
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             up;
  logic [CNT_W-1:0] prd_sh;

  assign at_zero = (cnt == '0);
  assign at_prd  = (cnt == prd_act);
  // next step goes upward
  assign rising  = (up && (cnt < prd_act)) || (!up && at_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      up      <= 1'b1;
      prd_sh  <= '0;
      prd_act <= '0;
    end else begin
      if (prd_wr)  prd_sh  <= wdata;
      if (at_zero) prd_act <= prd_sh;
      if (cnt_wr) begin
        cnt <= wdata;
      end else if (sync_load) begin
        cnt <= phase_val;
        up  <= 1'b1;
      end else if (up) begin
        if (cnt >= prd_act) begin
          if (prd_act == '0) begin
            cnt <= '0;
          end else begin
            cnt <= cnt - ONE;
            up  <= 1'b0;
          end
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (at_zero) begin
          up  <= 1'b1;
          cnt <= (prd_act == '0) ? '0 : ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/cpwm_qualifier.sv
module cpwm_qualifier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prd_act,
  input  logic             at_zero,
  input  logic             at_prd,
  input  logic             rising,
  output logic [CNT_W-1:0] cmp_act,
  output logic             ev_cmp,
  output logic             a_q
);
  logic [CNT_W-1:0] cmp_sh;
  logic [CNT_W-1:0] cmp_use;

  // At the zero point the value being loaded is the one that counts.
  assign cmp_use = at_zero ? cmp_sh : cmp_act;
  assign ev_cmp  = rising && (cnt == cmp_use) && (cmp_use < prd_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_sh  <= '0;
      cmp_act <= '0;
      a_q     <= 1'b0;
    end else begin
      if (cmp_wr)  cmp_sh  <= wdata;
      if (at_zero) cmp_act <= cmp_sh;
      if (at_prd)      a_q <= 1'b1;
      else if (ev_cmp) a_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_in,
  input  logic            enable,
  input  logic [DB_W-1:0] dly_a,
  input  logic [DB_W-1:0] dly_b,
  output logic            a_out,
  output logic            b_out
);
  localparam logic [DB_W-1:0] SAT = '1;

  logic [DB_W-1:0] hi_run;
  logic [DB_W-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (a_in) begin
      lo_run <= '0;
      if (hi_run != SAT) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != SAT) lo_run <= lo_run + 1'b1;
    end
  end

  assign a_out = enable ? (a_in && (hi_run >= dly_a))  : a_in;
  assign b_out = enable ? (!a_in && (lo_run >= dly_b)) : !a_in;
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_in,
  output logic             sync_out,
  output logic [CNT_W-1:0] count,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic [CNT_W-1:0] cnt, prd_act, cmp_act, phase_r;
  logic             at_zero, at_prd, rising, ev_cmp, a_q, a_db, b_db;
  logic             cnt_wr, sync_load;
  logic [FRC_W-1:0] frc_a, frc_b;
  logic             db_en, phs_en, master;
  logic [DB_W-1:0]  dly_a, dly_b;

  assign cnt_wr    = wr_en && (wr_addr == A_CNT);
  assign sync_load = sync_in && phs_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_r <= '0;
      frc_a   <= OVR_OFF;
      frc_b   <= OVR_OFF;
      db_en   <= 1'b0;
      phs_en  <= 1'b0;
      master  <= 1'b0;
      dly_a   <= '0;
      dly_b   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PHS:   phase_r <= wr_data;
        A_FRC:   {frc_b, frc_a} <= wr_data[2*FRC_W-1:0];
        A_CTRL:  {master, phs_en, db_en} <= wr_data[2:0];
        A_DLY_A: dly_a <= wr_data[DB_W-1:0];
        A_DLY_B: dly_b <= wr_data[DB_W-1:0];
        default: ;
      endcase
    end
  end

  cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n),
    .prd_wr(wr_en && (wr_addr == A_PRD)), .cnt_wr(cnt_wr), .sync_load(sync_load),
    .wdata(wr_data), .phase_val(phase_r),
    .cnt(cnt), .prd_act(prd_act), .at_zero(at_zero), .at_prd(at_prd), .rising(rising)
  );

  cpwm_qualifier #(.CNT_W(CNT_W)) u_aq (
    .clk(clk), .rst_n(rst_n),
    .cmp_wr(wr_en && (wr_addr == A_CMP)), .wdata(wr_data),
    .cnt(cnt), .prd_act(prd_act), .at_zero(at_zero), .at_prd(at_prd), .rising(rising),
    .cmp_act(cmp_act), .ev_cmp(ev_cmp), .a_q(a_q)
  );

  cpwm_deadband #(.DB_W(DB_W)) u_db (
    .clk(clk), .rst_n(rst_n), .a_in(a_q), .enable(db_en),
    .dly_a(dly_a), .dly_b(dly_b), .a_out(a_db), .b_out(b_db)
  );

  assign pwm_a    = apply_ovr(frc_a, a_db);
  assign pwm_b    = apply_ovr(frc_b, b_db);
  assign sync_out = master ? at_zero : sync_in;
  assign count    = cnt;
endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic             at_prd,
  input logic             ev_cmp,
  input logic             a_q,
  input logic             a_db,
  input logic             b_db,
  input logic             cnt_wr,
  input logic             sync_load
);
  // R1: free-running count moves by exactly one
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !sync_load && (prd_act != '0)) |=>
      (((cnt - $past(cnt)) == CNT_W'(1)) || (($past(cnt) - cnt) == CNT_W'(1))));

  // R2: live period and compare change only after a zero count
  a_r2_load_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(prd_act) && $stable(cmp_act)));

  // R3: period event raises A
  a_r3_set_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    at_prd |=> a_q);

  // R4: compare event on the upward leg drops A
  a_r4_clear_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmp && !at_prd) |=> !a_q);

  // R6: dead-band pair never overlaps
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_db && b_db));
endmodule

bind cpwm_channel cpwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .prd_act(prd_act), .cmp_act(cmp_act),
  .at_prd(at_prd), .ev_cmp(ev_cmp), .a_q(a_q), .a_db(a_db), .b_db(b_db),
  .cnt_wr(cnt_wr), .sync_load(sync_load)
);

// File: tb/cpwm_channel_bench.sv
module cpwm_channel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int DB_W  = 8;
  localparam int DB_SAT = (1 << DB_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             sync_in = 1'b0;
  logic             sync_out, pwm_a, pwm_b;
  logic [CNT_W-1:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_channel #(.CNT_W(CNT_W), .DB_W(DB_W)) u_cpwm_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .sync_out(sync_out), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_cnt, m_up, m_ps, m_pa, m_cs, m_ca, m_a, m_hi, m_lo;
  int m_da, m_db, m_den, m_pen, m_mst, m_phs, m_fa, m_fb;

  function automatic int ovr(int code, int lvl);
    if (code == 1) return 0;
    if (code == 2) return 1;
    return lvl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_ps = 0; m_pa = 0; m_cs = 0; m_ca = 0; m_a = 0;
      m_hi = 0; m_lo = 0; m_da = 0; m_db = 0; m_den = 0; m_pen = 0; m_mst = 0;
      m_phs = 0; m_fa = 0; m_fb = 0;
    end else begin
      int nc, nu, na, cu, wd;
      bit zero, upward;
      wd = int'(wr_data);
      zero = (m_cnt == 0);
      cu = zero ? m_cs : m_ca;
      upward = (m_up == 1 && m_cnt < m_pa) || (m_up == 0 && zero);
      na = m_a;
      if (m_cnt == m_pa) na = 1;
      else if (upward && m_cnt == cu && cu < m_pa) na = 0;
      nc = m_cnt; nu = m_up;
      if (wr_en && wr_addr == 2) nc = wd;
      else if (sync_in && m_pen == 1) begin nc = m_phs; nu = 1; end
      else if (m_up == 1) begin
        if (m_cnt < m_pa) nc = m_cnt + 1;
        else if (m_pa == 0) nc = 0;
        else begin nc = m_cnt - 1; nu = 0; end
      end else begin
        if (zero) begin nu = 1; nc = (m_pa == 0) ? 0 : 1; end
        else nc = m_cnt - 1;
      end
      if (m_a == 1) begin m_lo = 0; m_hi = (m_hi < DB_SAT) ? m_hi + 1 : m_hi; end
      else begin m_hi = 0; m_lo = (m_lo < DB_SAT) ? m_lo + 1 : m_lo; end
      if (zero) begin m_pa = m_ps; m_ca = m_cs; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ps = wd;
          3'd1: m_cs = wd;
          3'd3: m_phs = wd;
          3'd4: begin m_fa = wd % 4; m_fb = (wd / 4) % 4; end
          3'd5: begin m_den = wd % 2; m_pen = (wd / 2) % 2; m_mst = (wd / 4) % 2; end
          3'd6: m_da = wd % (DB_SAT + 1);
          3'd7: m_db = wd % (DB_SAT + 1);
          default: ;
        endcase
      end
      m_cnt = nc; m_up = nu; m_a = na;
    end
  end

  function automatic int exp_a();
    int v;
    v = (m_den == 1) ? ((m_a == 1 && m_hi >= m_da) ? 1 : 0) : m_a;
    return ovr(m_fa, v);
  endfunction

  function automatic int exp_b();
    int v;
    v = (m_den == 1) ? ((m_a == 0 && m_lo >= m_db) ? 1 : 0) : 1 - m_a;
    return ovr(m_fb, v);
  endfunction

  // per-cycle comparison, one ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R1 count", int'(count), m_cnt);
      check("R3 pwm_a", int'(pwm_a), exp_a());
      check("R6 pwm_b", int'(pwm_b), exp_b());
      check("R9 sync_out", int'(sync_out), (m_mst == 1) ? ((m_cnt == 0) ? 1 : 0) : int'(sync_in));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #3; end
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = CNT_W'(data);
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_count(int v);
    for (int i = 0; i < 2000; i++) begin
      if (int'(count) == v) break;
      step();
    end
  endtask

  task automatic measure(int n, output int ha, output int hb, output int ov);
    ha = 0; hb = 0; ov = 0;
    for (int i = 0; i < n; i++) begin
      ha += int'(pwm_a); hb += int'(pwm_b); ov += int'(pwm_a & pwm_b);
      step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ha, hb, ov, mx;
    step(3);
    // reset state
    check("R1 reset count", int'(count), 0);
    check("R3 reset pwm_a", int'(pwm_a), 0);
    check("R7 reset pwm_b", int'(pwm_b), 1);
    rst_n = 1'b1;

    // R3 R4 R7: basic duty in bypass, P=10 C=4
    wr(0, 10); wr(1, 4); step(40);
    measure(20, ha, hb, ov);
    check("R3 high time P+C", ha, 14);
    check("R7 bypass complement", hb, 6);
    check("R7 bypass no overlap", ov, 0);

    // R2: period written mid-cycle takes effect after zero
    wait_count(0); step(2);
    wr(0, 6);
    mx = 0;
    for (int i = 0; i < 100 && int'(count) != 0; i++) begin
      if (int'(count) > mx) mx = int'(count);
      step();
    end
    check("R2 old period peak", mx, 10);
    step(); mx = 0;
    for (int i = 0; i < 100 && int'(count) != 0; i++) begin
      if (int'(count) > mx) mx = int'(count);
      step();
    end
    check("R2 new period peak", mx, 6);
    wr(0, 10); step(40);

    // R12: zero compare, then switch to non-zero
    wr(1, 0); step(40);
    measure(20, ha, hb, ov);
    check("R12 zero compare high time", ha, 10);
    wait_count(10);
    wr(1, 3);
    measure(20, ha, hb, ov);
    check("R12 first period after 0->3", ha, 13);

    // R5: compare at or above period
    wr(1, 12); step(40);
    measure(20, ha, hb, ov);
    check("R5 compare above period", ha, 20);
    wr(1, 10); step(40);
    measure(20, ha, hb, ov);
    check("R5 compare equals period", ha, 20);
    wr(1, 4); step(40);

    // R6: full dead-band
    wr(6, 2); wr(7, 3); wr(5, 1); step(40);
    measure(20, ha, hb, ov);
    check("R6 delayed A high time", ha, 12);
    check("R6 delayed B high time", hb, 3);
    check("R6 overlap", ov, 0);

    // R8: overrides
    wr(4, 2 | (1 << 2)); step(2);
    measure(20, ha, hb, ov);
    check("R8 A forced high", ha, 20);
    check("R8 B forced low", hb, 0);
    wr(4, 1 | (2 << 2)); step(2);
    measure(20, ha, hb, ov);
    check("R8 A forced low", ha, 0);
    check("R8 B forced high", hb, 20);
    wr(4, 3 | (0 << 2)); step(2);
    measure(20, ha, hb, ov);
    check("R8 released A", ha, 12);
    check("R8 released B", hb, 3);

    // R10: counter preset
    wr(2, 7);
    check("R10 preset value", int'(count), 7);
    mx = int'(count);
    step();
    check("R10 continues by one", (int'(count) == mx + 1 || int'(count) == mx - 1) ? 1 : 0, 1);

    // R11: phase load on sync
    wr(3, 5); wr(5, 3); step(7);
    sync_in = 1'b1; step(); sync_in = 1'b0;
    check("R11 phase loaded", int'(count), 5);
    step();
    check("R11 counts up after load", int'(count), 6);

    // R9: sync output, master then pass-through
    wr(5, 5); wait_count(0);
    check("R9 master pulse at zero", int'(sync_out), 1);
    step();
    check("R9 master quiet off zero", int'(sync_out), 0);
    wr(5, 1);
    sync_in = 1'b1; #1;
    check("R9 pass-through high", int'(sync_out), 1);
    sync_in = 1'b0; #1;
    check("R9 pass-through low", int'(sync_out), 0);
    step(30);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule